// File: doc/BRIEF.md
# Command/Status Flash Bank Sequencer

This block erases or programs one bank of a byte-wide flash device that takes commands as bus writes and reports progress through a status register. A requester pulses `start_i` with `op_i` selecting erase or program. The sequencer then drives the flash bus by itself until it pulses `done_o` with a result code on `err_o`. While it programs, it fetches the byte for each flash offset from an external buffer through a combinational lookup port (`buf_addr_o` out, `buf_data_i` back in the same cycle).

An erase is a setup/confirm command pair. A program is a setup command, a fixed settle delay and the data byte, repeated for every byte in ascending order. After each erase confirm and after each data byte, the block asks for status with an explicit read-status command and reads the status byte, until the ready bit is set or the attempt limit runs out. Every operation ends the same way, including operations that failed: a clear-status command, a reset command, and then a read-back of the whole bank against the expected contents.

The bank size, the settle delay in clock cycles and the poll attempt limit are parameters. The defaults are an 8 KiB bank, 50 cycles and 1,000,000 attempts.

Top module: `fbs_seq`

## Requirements
- R1: An erase writes 0x20 and then 0xD0 to bank offset 0 on two consecutive cycles.
- R2: After an erase confirm or a program data write, the block writes 0x70 to offset 0 and reads offset 0 in the next cycle. It repeats this pair until bit 7 of the byte read is 1. Write strobe and read strobe are never high together.
- R3: If POLL_MAX status reads in a row show bit 7 as 0, the operation stops polling with error code 1 (timeout). Exactly POLL_MAX read-status commands are issued for that poll.
- R4: Every operation, whether it succeeds or fails, writes 0x50 and then 0xFF to offset 0 before the read-back starts.
- R5: A program visits offsets in ascending order. For each offset it writes 0x40 to the offset, waits DELAY_CYC cycles, and then writes the buffer byte for that offset to the same offset. The data write comes exactly DELAY_CYC+1 cycles after the setup write.
- R6: A ready status byte with any of bits 5..3 set (mask 0x38) gives error code 2 (status fault).
- R7: The read-back reads offsets upward from 0. It expects 0xFF after an erase and the buffer byte after a program. The first mismatch ends the read-back with error code 3 (verify). Without a mismatch, every offset is read once.
- R8: `done_o` is high for exactly one cycle. `err_o` holds the result until the next start. Code 0 means success. The first error recorded in an operation wins over later ones.
- R9: After a timeout or a status fault on one byte, no further offset is programmed.
- R10: While reset is asserted, `done_o`, `fl_we_o` and `fl_re_o` are 0 and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation; sampled only when idle |
| op_i | input | 1 | 0 = erase bank, 1 = program bank |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| err_o | output | 2 | 0 ok, 1 timeout, 2 status fault, 3 verify mismatch |
| fl_addr_o | output | ADDR_W | Flash byte offset within the bank |
| fl_wdata_o | output | 8 | Flash write data or command |
| fl_we_o | output | 1 | Flash write strobe, one cycle per write |
| fl_re_o | output | 1 | Flash read strobe; read data is sampled in the same cycle |
| fl_rdata_i | input | 8 | Flash read data (status byte or array byte) |
| buf_addr_o | output | ADDR_W | Buffer lookup offset |
| buf_data_i | input | 8 | Buffer byte for `buf_addr_o`, valid in the same cycle |

## Verification
The assertions take three things for granted. The flash returns valid data combinationally in the cycle the read strobe is high. The buffer answers `buf_addr_o` in the same cycle. `start_i` has an effect only when the block is idle. The bench flash model meets these conditions: it updates its array and mode on the write strobe at the clock edge and drives read data continuously from its current state. The bench raises `start_i` for exactly one cycle, and only after the previous `done_o`. Faults are injected inside the model by knobs that hold the status busy, set bit 4 of the status on one chosen byte, or make one byte refuse to change. The block's inputs therefore always follow the device protocol.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_STATUS  = 2'd2,
    ERR_VERIFY  = 2'd3
  } fbs_err_e;

  typedef enum logic [3:0] {
    S_IDLE, S_E_SETUP, S_E_CONF, S_P_SETUP, S_P_WAIT, S_P_DATA,
    S_POLL_CMD, S_POLL_RD, S_CLR, S_RST, S_VFY, S_DONE
  } fbs_state_e;

  localparam logic       OP_ERASE        = 1'b0;
  localparam logic       OP_PROG         = 1'b1;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_READ_STAT   = 8'h70;
  localparam logic [7:0] CMD_CLR_STAT    = 8'h50;
  localparam logic [7:0] CMD_RESET       = 8'hFF;
  localparam logic [7:0] ERASED_BYTE     = 8'hFF;
  localparam int         ST_READY_BIT    = 7;
  localparam logic [7:0] ST_FAULT_MASK   = 8'h38;
endpackage

// File: rtl/fbs_delay_ctr.sv
module fbs_delay_ctr #(
  parameter int DELAY_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic elapsed_o
);
  localparam int W = (DELAY_CYC > 1) ? $clog2(DELAY_CYC) : 1;
  localparam logic [W-1:0] LAST = W'(DELAY_CYC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (run_i && !elapsed_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign elapsed_o = (cnt_q == LAST);

  p_delay_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/fbs_poll_ctr.sv
module fbs_poll_ctr #(
  parameter int POLL_MAX = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expired_o
);
  localparam int W = $clog2(POLL_MAX + 1);
  localparam logic [W-1:0] LIMIT = W'(POLL_MAX);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);

  p_poll_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
endmodule

// File: rtl/fbs_addr_ctr.sv
module fbs_addr_ctr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clr_i)   addr_q <= '0;
    else if (inc_i)   addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;

  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |-> !last_o);
endmodule

// File: rtl/fbs_seq.sv
module fbs_seq
  import fbs_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DELAY_CYC = 50,
  parameter int POLL_MAX  = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  output logic              done_o,
  output logic [1:0]        err_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  output logic              fl_we_o,
  output logic              fl_re_o,
  input  logic [7:0]        fl_rdata_i,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_data_i
);
  fbs_state_e        state_q, state_d;
  logic              op_q;
  fbs_err_e          err_q, err_d;
  logic [ADDR_W-1:0] cur_addr;
  logic              addr_last, addr_clr, addr_inc;
  logic              dly_done, poll_exp, poll_clr;
  logic              st_ready, st_fault, vfy_miss;
  logic [7:0]        vfy_exp;

  fbs_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i, .rst_ni, .clr_i(addr_clr), .inc_i(addr_inc),
    .addr_o(cur_addr), .last_o(addr_last)
  );

  fbs_delay_ctr #(.DELAY_CYC(DELAY_CYC)) u_dly (
    .clk_i, .rst_ni, .clr_i(state_q == S_P_SETUP),
    .run_i(state_q == S_P_WAIT), .elapsed_o(dly_done)
  );

  fbs_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk_i, .rst_ni, .clr_i(poll_clr),
    .inc_i(state_q == S_POLL_CMD), .expired_o(poll_exp)
  );

  assign st_ready = fl_rdata_i[ST_READY_BIT];
  assign st_fault = |(fl_rdata_i & ST_FAULT_MASK);
  assign vfy_exp  = (op_q == OP_PROG) ? buf_data_i : ERASED_BYTE;
  assign vfy_miss = (fl_rdata_i != vfy_exp);
  assign poll_clr = (state_q == S_E_CONF) || (state_q == S_P_DATA);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (start_i) state_d = (op_i == OP_PROG) ? S_P_SETUP : S_E_SETUP;
      S_E_SETUP:  state_d = S_E_CONF;
      S_E_CONF:   state_d = S_POLL_CMD;
      S_P_SETUP:  state_d = S_P_WAIT;
      S_P_WAIT:   if (dly_done) state_d = S_P_DATA;
      S_P_DATA:   state_d = S_POLL_CMD;
      S_POLL_CMD: state_d = S_POLL_RD;
      S_POLL_RD: begin
        if (st_ready) begin
          if (st_fault || op_q == OP_ERASE || addr_last) state_d = S_CLR;
          else                                           state_d = S_P_SETUP;
        end else if (poll_exp) begin
          state_d = S_CLR;
        end else begin
          state_d = S_POLL_CMD;
        end
      end
      S_CLR:      state_d = S_RST;
      S_RST:      state_d = S_VFY;
      S_VFY:      if (vfy_miss || addr_last) state_d = S_DONE;
      S_DONE:     state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  // result code, first error wins
  always_comb begin
    err_d = err_q;
    if (state_q == S_IDLE && start_i) begin
      err_d = ERR_NONE;
    end else if (err_q == ERR_NONE) begin
      if (state_q == S_POLL_RD && st_ready && st_fault)      err_d = ERR_STATUS;
      else if (state_q == S_POLL_RD && !st_ready && poll_exp) err_d = ERR_TIMEOUT;
      else if (state_q == S_VFY && vfy_miss)                  err_d = ERR_VERIFY;
    end
  end

  assign addr_clr = (state_q == S_IDLE) || (state_q == S_RST);
  assign addr_inc = (state_q == S_POLL_RD && st_ready && !st_fault &&
                     op_q == OP_PROG && !addr_last) ||
                    (state_q == S_VFY && !vfy_miss && !addr_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_ERASE;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (state_q == S_IDLE && start_i) op_q <= op_i;
    end
  end

  // flash bus
  always_comb begin
    fl_we_o    = 1'b0;
    fl_re_o    = 1'b0;
    fl_addr_o  = '0;
    fl_wdata_o = '0;
    unique case (state_q)
      S_E_SETUP:  begin fl_we_o = 1'b1; fl_wdata_o = CMD_ERASE_SETUP; end
      S_E_CONF:   begin fl_we_o = 1'b1; fl_wdata_o = CMD_ERASE_GO;    end
      S_P_SETUP:  begin fl_we_o = 1'b1; fl_addr_o = cur_addr; fl_wdata_o = CMD_PROG_SETUP; end
      S_P_DATA:   begin fl_we_o = 1'b1; fl_addr_o = cur_addr; fl_wdata_o = buf_data_i;     end
      S_POLL_CMD: begin fl_we_o = 1'b1; fl_wdata_o = CMD_READ_STAT;   end
      S_POLL_RD:  fl_re_o = 1'b1;
      S_CLR:      begin fl_we_o = 1'b1; fl_wdata_o = CMD_CLR_STAT;    end
      S_RST:      begin fl_we_o = 1'b1; fl_wdata_o = CMD_RESET;       end
      S_VFY:      begin fl_re_o = 1'b1; fl_addr_o = cur_addr;         end
      default: ;
    endcase
  end

  assign buf_addr_o = cur_addr;
  assign done_o     = (state_q == S_DONE);
  assign err_o      = err_q;

  p_erase_pair_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_E_SETUP) |=> (fl_we_o && fl_wdata_o == CMD_ERASE_GO && fl_addr_o == '0));
  p_read_after_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POLL_CMD) |=> (fl_re_o && fl_addr_o == '0));
  p_we_re_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_re_o));
  p_clr_then_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CLR) |=> (fl_we_o && fl_wdata_o == CMD_RESET));
  p_verify_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_VFY) |-> ($past(state_q) == S_RST || $past(state_q) == S_VFY));
  p_data_after_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_P_DATA) |-> ($past(state_q) == S_P_WAIT));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE && err_q != ERR_NONE) |=> (err_q == $past(err_q)));
endmodule

// File: tb/fbs_seq_test.sv
`timescale 1ns/1ps
module fbs_seq_test;
  localparam int AW   = 6;
  localparam int NB   = 1 << AW;
  localparam int DLY  = 3;
  localparam int PMAX = 12;
  localparam int BIG  = 32'h7fff_ffff;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op = 1'b0;
  logic done;
  logic [1:0] err;
  logic [AW-1:0] fl_addr, buf_addr;
  logic [7:0] fl_wdata, fl_rdata, buf_data;
  logic fl_we, fl_re;

  always #10 clk = ~clk;

  fbs_seq #(.ADDR_W(AW), .DELAY_CYC(DLY), .POLL_MAX(PMAX)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .done_o(done), .err_o(err),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_we_o(fl_we), .fl_re_o(fl_re),
    .fl_rdata_i(fl_rdata), .buf_addr_o(buf_addr), .buf_data_i(buf_data)
  );

  // buffer
  int seed = 3;
  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + seed) & 8'hFF);
  endfunction
  assign buf_data = pat(int'(buf_addr));

  // fault knobs
  int hang_erase = 0, erase_stuck = -1, hang_addr = -1, inj_addr = -1, skip_addr = -1;

  // flash model
  logic [7:0] mem [NB];
  int busy = 0, pend = 0, smode = 0, vfy_phase = 0;
  logic [7:0] ebits = 8'h00, last_wr = 8'h00;
  int cyc = 0, t40 = 0, a40 = 0;
  int n70 = 0, nstat = 0, nvfy = 0, ndata = 0, n40 = 0, gap_bad = 0, clr_rst = 0, pair_ok = 0;

  assign fl_rdata = smode != 0 ? ({(busy == 0), 7'b0} | ebits) : mem[fl_addr];

  initial for (int i = 0; i < NB; i++) mem[i] = 8'h5A;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (busy > 0) busy <= busy - 1;
    if (fl_re) begin
      if (smode != 0) nstat <= nstat + 1;
      else if (vfy_phase != 0) nvfy <= nvfy + 1;
    end
    if (fl_we) begin
      last_wr <= fl_wdata;
      if (pend == 1) begin
        pend <= 0;
        if (fl_wdata == 8'hD0) begin
          smode <= 1;
          if (last_wr == 8'h20 && fl_addr == '0) pair_ok <= pair_ok + 1;
          if (hang_erase != 0) busy <= BIG;
          else begin
            busy <= 4;
            for (int i = 0; i < NB; i++) mem[i] <= (i == erase_stuck) ? 8'h00 : 8'hFF;
          end
        end
      end else if (pend == 2) begin
        pend  <= 0;
        smode <= 1;
        ndata <= ndata + 1;
        if (cyc - t40 != DLY + 1 || int'(fl_addr) != a40) gap_bad <= gap_bad + 1;
        if (int'(fl_addr) != skip_addr) mem[fl_addr] <= mem[fl_addr] & fl_wdata;
        busy <= (int'(fl_addr) == hang_addr) ? BIG : 2;
        if (int'(fl_addr) == inj_addr) ebits <= 8'h10;
      end else begin
        case (fl_wdata)
          8'h20: begin pend <= 1; vfy_phase <= 0; end
          8'h40: begin pend <= 2; vfy_phase <= 0; n40 <= n40 + 1; t40 <= cyc; a40 <= int'(fl_addr); end
          8'h70: begin smode <= 1; n70 <= n70 + 1; end
          8'h50: ebits <= 8'h00;
          8'hFF: begin
            smode <= 0; busy <= 0; vfy_phase <= 1;
            if (last_wr == 8'h50) clr_rst <= clr_rst + 1;
          end
          default: ;
        endcase
      end
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-operation deltas
  int d70, dstat, dvfy, ddata, d40, dgap, dclr, dpair;
  logic [1:0] res;

  task automatic run_op(input logic o);
    int s70 = n70, sst = nstat, svf = nvfy, sda = ndata, s40 = n40, sg = gap_bad, sc = clr_rst, sp = pair_ok;
    int w = 0;
    @(negedge clk); start = 1'b1; op = o;
    @(negedge clk); start = 1'b0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    if (!done) chk(0, "R8 done never seen", 0, 1);
    res = err;
    @(negedge clk);
    d70 = n70 - s70; dstat = nstat - sst; dvfy = nvfy - svf; ddata = ndata - sda;
    d40 = n40 - s40; dgap = gap_bad - sg; dclr = clr_rst - sc; dpair = pair_ok - sp;
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
  endtask

  task automatic clear_knobs;
    hang_erase = 0; erase_stuck = -1; hang_addr = -1; inj_addr = -1; skip_addr = -1;
  endtask

  function automatic int mem_eq_pat();
    for (int i = 0; i < NB; i++) if (mem[i] != pat(i)) return 0;
    return 1;
  endfunction

  function automatic int mem_all_ff();
    for (int i = 0; i < NB; i++) if (mem[i] != 8'hFF) return 0;
    return 1;
  endfunction

  task automatic t_reset;
    #5;
    chk(done == 0 && fl_we == 0 && fl_re == 0, "R10 strobes low in reset", int'({done, fl_we, fl_re}), 0);
    chk(err == 2'd0, "R10 err zero in reset", int'(err), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_erase_ok;
    clear_knobs();
    run_op(1'b0);
    chk(res == 2'd0, "R8 erase ok code", int'(res), 0);
    chk(dpair == 1, "R1 erase setup/confirm pair", dpair, 1);
    chk(mem_all_ff() == 1, "R1 bank erased", mem_all_ff(), 1);
    chk(d70 == dstat && d70 >= 2, "R2 status cmd per read", d70, dstat);
    chk(dclr == 1, "R4 clear then reset", dclr, 1);
    chk(dvfy == NB, "R7 full read-back", dvfy, NB);
    repeat (4) @(negedge clk);
    chk(err == 2'd0, "R8 err held", int'(err), 0);
  endtask

  task automatic t_prog_ok(input int s);
    clear_knobs();
    run_op(1'b0);
    seed = s;
    run_op(1'b1);
    chk(res == 2'd0, "R8 program ok code", int'(res), 0);
    chk(mem_eq_pat() == 1, "R5 bank holds buffer", mem_eq_pat(), 1);
    chk(d40 == NB && ddata == NB, "R5 setup/data per byte", ddata, NB);
    chk(dgap == 0, "R5 setup-to-data spacing and address", dgap, 0);
    chk(d70 == dstat, "R2 status cmd per read", d70, dstat);
    chk(dvfy == NB, "R7 full read-back after program", dvfy, NB);
  endtask

  task automatic t_erase_timeout;
    clear_knobs();
    hang_erase = 1;
    run_op(1'b0);
    chk(res == 2'd1, "R3 erase timeout code", int'(res), 1);
    chk(d70 == PMAX, "R3 poll attempts", d70, PMAX);
    chk(dclr == 1, "R4 clear/reset after timeout", dclr, 1);
  endtask

  task automatic t_prog_status;
    clear_knobs();
    run_op(1'b0);
    seed = 11; inj_addr = 5;
    run_op(1'b1);
    chk(res == 2'd2, "R6 status fault code", int'(res), 2);
    chk(ddata == 6, "R9 stop after faulted byte", ddata, 6);
    chk(dclr == 1, "R4 clear/reset after fault", dclr, 1);
  endtask

  task automatic t_prog_timeout;
    clear_knobs();
    run_op(1'b0);
    seed = 20; hang_addr = 3;
    run_op(1'b1);
    chk(res == 2'd1, "R8 first error kept over verify", int'(res), 1);
    chk(ddata == 4, "R9 stop after timed-out byte", ddata, 4);
    chk(d70 == dstat, "R2 status cmd per read", d70, dstat);
    chk(dclr == 1, "R4 clear/reset after program timeout", dclr, 1);
  endtask

  task automatic t_prog_verify;
    clear_knobs();
    run_op(1'b0);
    seed = 3; skip_addr = 9;
    run_op(1'b1);
    chk(res == 2'd3, "R7 program verify code", int'(res), 3);
    chk(dvfy == 10, "R7 read-back stops at first mismatch", dvfy, 10);
  endtask

  task automatic t_erase_verify;
    clear_knobs();
    erase_stuck = 4;
    run_op(1'b0);
    chk(res == 2'd3, "R7 erase verify code", int'(res), 3);
    chk(dvfy == 5, "R7 erase read-back stops", dvfy, 5);
    clear_knobs();
    run_op(1'b0);
    chk(res == 2'd0, "R8 code cleared by next start", int'(res), 0);
  endtask

  initial begin
    t_reset();
    t_erase_ok();
    t_prog_ok(3);
    t_prog_ok(100);
    t_erase_timeout();
    t_prog_status();
    t_prog_timeout();
    t_prog_verify();
    t_erase_verify();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule